// File: doc/BRIEF.md
# Byte-Wide Host Register Port for a 24-bit Counter

This block is the host side of a 24-bit position counter peripheral. A processor reaches it over an 8-bit data bus using four control lines: an active-low chip enable, a command/data select, and active-low read and write strobes. With the select line high the host writes a command byte or reads a status byte. With the select line low it moves data bytes to or from the 24-bit registers, one byte per strobe. An internal pointer chooses the byte and advances by itself after every data byte, so a full 24-bit value moves in three back-to-back accesses with the least significant byte first.

A command byte does one of three things. It moves the pointer, or it changes the counting mode bits, or it fires one-cycle action pulses toward the counter core: load, latch, clear, and interrupt acknowledge. The block drives out the preload and reference values that the host writes. It returns bytes of the counter's latch value and of the reference value. It also builds an 8-bit status byte from the core's flag lines. The pad is split into an input byte, an output byte and an output enable, so the three-state driver can sit at the chip boundary. All control lines are sampled on the system clock, and every access takes effect once, at the first clock edge that sees its strobe asserted.

Top module: `bbi_host_if`

## Requirements
- R1: After reset the pointer is 0, the mode bits are 0, the preload and reference outputs are 0, every action pulse is low and the status register is 0.
- R2: `bus_oe` is high exactly while `cs_n` and `rd_n` are both low. `bus_out` holds the byte captured by the most recent read.
- R3: A data write stores the `bus_in` byte into the byte chosen by the pointer. Pointer 0, 1 and 2 select preload bits 7:0, 15:8 and 23:16. Pointer 3, 4 and 5 select reference bits 7:0, 15:8 and 23:16.
- R4: After each data read or data write the pointer advances by one. From 5 it wraps to 0.
- R5: A data read returns `latch_val` bits 7:0, 15:8 and 23:16 for pointer 0, 1 and 2, and reference bits 7:0, 15:8 and 23:16 for pointer 3, 4 and 5. The byte is captured at the clock edge that first sees the strobe low.
- R6: A strobe held low for several cycles counts as a single access. It moves the pointer once and fires each action once.
- R7: A command with bit 7 = 1 and bit 6 = 0 loads the pointer from bits 2:0. The values 6 and 7 load 0.
- R8: A command with bit 7 = 0 is an action. Bit 0 fires `load_pulse`, bit 1 `latch_pulse`, bit 2 `clear_pulse` and bit 3 `irq_ack_pulse`. Each pulse is high for exactly the one cycle after the accepting edge, and any combination may fire together.
- R9: A command with bits 7:6 = 11 loads `mode` from bits 3:0 and leaves the pointer unchanged.
- R10: A status read returns the status register, which is refreshed every clock. Its bits are: bit 7 abnormal-input flag, 6 interrupt, 5 coincidence, 4 direction, 3 latch-valid, 2 Z level, 1 B level, 0 A level.
- R11: While `cs_n` is high the strobes are ignored. Nothing is written, the pointer holds, no pulse fires and `bus_oe` stays low.
- R12: Status reads and action or mode commands leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip enable, active low |
| cmd_sel | input | 1 | 1 = command/status, 0 = data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Byte from the host |
| bus_out | output | 8 | Byte to the host |
| bus_oe | output | 1 | Pad output enable |
| latch_val | input | 24 | Counter latch register contents |
| abn_flag | input | 1 | Abnormal-input flag from the core |
| irq_state | input | 1 | Interrupt output state |
| eq_flag | input | 1 | Coincidence flag |
| dir_flag | input | 1 | Count direction |
| latch_valid | input | 1 | Latch register holds a fresh value |
| pin_a | input | 1 | Level of input A |
| pin_b | input | 1 | Level of input B |
| pin_z | input | 1 | Level of input Z |
| preload_val | output | 24 | Preload register |
| ref_val | output | 24 | Reference register |
| mode | output | 4 | Counting mode bits |
| load_pulse | output | 1 | Load preload into counter |
| latch_pulse | output | 1 | Latch counter value |
| clear_pulse | output | 1 | Clear counter |
| irq_ack_pulse | output | 1 | Reset interrupt |

## Verification
The assertions assume that the control lines are synchronous to `clk`. They also assume that a read strobe and a write strobe are never asserted together. A one-access-per-low-phase check relies on the host deasserting a strobe between accesses. The bench changes every control and data input only on falling clock edges. It releases each strobe before starting the next access and never asserts both strobes at once. It also keeps the core flag inputs steady for at least two edges before a status read, so the registered status has settled.

// File: rtl/bbi_pkg.sv
package bbi_pkg;

  typedef struct packed {
    logic data_rd;
    logic data_wr;
    logic stat_rd;
    logic cmd_wr;
  } bus_evt_t;

  typedef enum logic [1:0] {
    CK_ACTION = 2'd0,
    CK_POINTER = 2'd1,
    CK_MODE = 2'd2
  } cmd_kind_t;

  function automatic cmd_kind_t cmd_kind(input logic [7:0] b);
    if (!b[7]) return CK_ACTION;
    else if (!b[6]) return CK_POINTER;
    else return CK_MODE;
  endfunction

endpackage

// File: rtl/bbi_strobe_decode.sv
module bbi_strobe_decode
  import bbi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     cmd_sel,
  input  logic     rd_n,
  input  logic     wr_n,
  output bus_evt_t evt
);
  logic rd_act, wr_act, rd_prev, wr_prev, rd_first, wr_first;

  assign rd_act = !cs_n && !rd_n && wr_n;
  assign wr_act = !cs_n && !wr_n && rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_act;
      wr_prev <= wr_act;
    end
  end

  assign rd_first = rd_act && !rd_prev;
  assign wr_first = wr_act && !wr_prev;

  always_comb begin
    evt.data_rd = rd_first && !cmd_sel;
    evt.stat_rd = rd_first && cmd_sel;
    evt.data_wr = wr_first && !cmd_sel;
    evt.cmd_wr  = wr_first && cmd_sel;
  end

  // R6: a strobe held low is accepted only once
  a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.data_rd || evt.stat_rd) |=> !(evt.data_rd || evt.stat_rd));
  a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.data_wr || evt.cmd_wr) |=> !(evt.data_wr || evt.cmd_wr));
  // R11: nothing accepted while disabled
  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (evt == '0));

endmodule

// File: rtl/bbi_cmd_unit.sv
module bbi_cmd_unit
  import bbi_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int NPTR   = 6,
  parameter int PTR_W  = 3,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic [BUS_W-1:0]  din,
  output logic [PTR_W-1:0]  ptr,
  output logic [MODE_W-1:0] mode,
  output logic              load_pulse,
  output logic              latch_pulse,
  output logic              clear_pulse,
  output logic              irq_ack_pulse
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NPTR - 1);
  localparam logic [PTR_W-1:0] PTR_LIM  = PTR_W'(NPTR);

  cmd_kind_t        kind;
  logic [PTR_W-1:0] ptr_field;
  logic             is_act;

  assign kind      = cmd_kind(din[7:0]);
  assign ptr_field = din[PTR_W-1:0];
  assign is_act    = evt.cmd_wr && (kind == CK_ACTION);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      mode <= '0;
    end else if (evt.data_rd || evt.data_wr) begin
      ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end else if (evt.cmd_wr) begin
      if (kind == CK_POINTER)
        ptr <= (ptr_field >= PTR_LIM) ? '0 : ptr_field;
      else if (kind == CK_MODE)
        mode <= din[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_pulse    <= 1'b0;
      latch_pulse   <= 1'b0;
      clear_pulse   <= 1'b0;
      irq_ack_pulse <= 1'b0;
    end else begin
      load_pulse    <= is_act && din[0];
      latch_pulse   <= is_act && din[1];
      clear_pulse   <= is_act && din[2];
      irq_ack_pulse <= is_act && din[3];
    end
  end

  // R4: pointer never leaves its range and steps with wrap
  a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PTR_LIM);
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.data_rd || evt.data_wr) |=>
      (ptr == (($past(ptr) == PTR_LAST) ? '0 : $past(ptr) + 1'b1)));
  // R8: a pulse only follows an accepted command write
  a_r8_pulse_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse || latch_pulse || clear_pulse || irq_ack_pulse) |-> $past(evt.cmd_wr));
  a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);
  // R12: status reads leave the pointer alone
  a_r12_status_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stat_rd |=> $stable(ptr));

endmodule

// File: rtl/bbi_byte_regs.sv
module bbi_byte_regs #(
  parameter int BUS_W  = 8,
  parameter int CNT_W  = 24,
  parameter int NBYTES = 3,
  parameter int PTR_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] ptr,
  input  logic [BUS_W-1:0] din,
  input  logic [CNT_W-1:0] latch_val,
  output logic [CNT_W-1:0] preload_val,
  output logic [CNT_W-1:0] ref_val,
  output logic [BUS_W-1:0] rd_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload_val <= '0;
      ref_val     <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (ptr == PTR_W'(i))          preload_val[i*BUS_W +: BUS_W] <= din;
        if (ptr == PTR_W'(i + NBYTES)) ref_val[i*BUS_W +: BUS_W]     <= din;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (ptr == PTR_W'(i))          rd_byte = latch_val[i*BUS_W +: BUS_W];
      if (ptr == PTR_W'(i + NBYTES)) rd_byte = ref_val[i*BUS_W +: BUS_W];
    end
  end

  // R3: a write leaves bytes outside the pointer untouched
  a_r3_ref_kept_on_preload_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr < PTR_W'(NBYTES)) |=> $stable(ref_val));

endmodule

// File: rtl/bbi_host_if.sv
module bbi_host_if
  import bbi_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CNT_W  = 24,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  input  logic [CNT_W-1:0]  latch_val,
  input  logic              abn_flag,
  input  logic              irq_state,
  input  logic              eq_flag,
  input  logic              dir_flag,
  input  logic              latch_valid,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              pin_z,
  output logic [CNT_W-1:0]  preload_val,
  output logic [CNT_W-1:0]  ref_val,
  output logic [MODE_W-1:0] mode,
  output logic              load_pulse,
  output logic              latch_pulse,
  output logic              clear_pulse,
  output logic              irq_ack_pulse
);
  localparam int NBYTES = CNT_W / BUS_W;
  localparam int NPTR   = 2 * NBYTES;
  localparam int PTR_W  = $clog2(NPTR);

  bus_evt_t         evt;
  logic [PTR_W-1:0] ptr;
  logic [BUS_W-1:0] rd_byte, rd_buf;
  logic [7:0]       status_q;

  bbi_strobe_decode u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_sel(cmd_sel),
    .rd_n(rd_n), .wr_n(wr_n), .evt(evt)
  );

  bbi_cmd_unit #(.BUS_W(BUS_W), .NPTR(NPTR), .PTR_W(PTR_W), .MODE_W(MODE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .evt(evt), .din(bus_in), .ptr(ptr), .mode(mode),
    .load_pulse(load_pulse), .latch_pulse(latch_pulse),
    .clear_pulse(clear_pulse), .irq_ack_pulse(irq_ack_pulse)
  );

  bbi_byte_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W), .NBYTES(NBYTES), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(evt.data_wr), .ptr(ptr), .din(bus_in),
    .latch_val(latch_val), .preload_val(preload_val), .ref_val(ref_val),
    .rd_byte(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else status_q <= {abn_flag, irq_state, eq_flag, dir_flag,
                      latch_valid, pin_z, pin_b, pin_a};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rd_buf <= '0;
    else if (evt.data_rd) rd_buf <= rd_byte;
    else if (evt.stat_rd) rd_buf <= BUS_W'(status_q);
  end

  assign bus_oe  = !cs_n && !rd_n;
  assign bus_out = rd_buf;

  // R2: the output byte does not change while the host is reading it
  a_r2_stable_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe) && !evt.data_rd && !evt.stat_rd) |-> $stable(bus_out));
  // R11: disabled host port leaves the data registers alone
  a_r11_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(preload_val) && $stable(ref_val)));

endmodule

// File: tb/bbi_host_if_bench.sv
module bbi_host_if_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, cmd_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic bus_oe;
  logic [23:0] latch_val = '0;
  logic abn_flag = 0, irq_state = 0, eq_flag = 0, dir_flag = 0;
  logic latch_valid = 0, pin_a = 0, pin_b = 0, pin_z = 0;
  logic [23:0] preload_val, ref_val;
  logic [3:0] mode;
  logic load_pulse, latch_pulse, clear_pulse, irq_ack_pulse;

  int n_checks = 0, n_errors = 0;
  logic [3:0] pulses_seen;

  always #2.5 clk = ~clk;

  bbi_host_if u_bbi_host_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_sel(cmd_sel), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .latch_val(latch_val),
    .abn_flag(abn_flag), .irq_state(irq_state), .eq_flag(eq_flag), .dir_flag(dir_flag),
    .latch_valid(latch_valid), .pin_a(pin_a), .pin_b(pin_b), .pin_z(pin_z),
    .preload_val(preload_val), .ref_val(ref_val), .mode(mode),
    .load_pulse(load_pulse), .latch_pulse(latch_pulse),
    .clear_pulse(clear_pulse), .irq_ack_pulse(irq_ack_pulse)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [3:0] pulse_vec();
    return {irq_ack_pulse, clear_pulse, latch_pulse, load_pulse};
  endfunction

  // one write access; pulses_seen holds the outputs one cycle after acceptance
  task automatic host_wr(input logic sel, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    cs_n = !en; cmd_sel = sel; bus_in = d; wr_n = 1'b0;
    @(negedge clk);
    pulses_seen = pulse_vec();
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic host_rd(input logic sel, output logic [7:0] d, input int hold = 1);
    @(negedge clk);
    cs_n = 1'b0; cmd_sel = sel; rd_n = 1'b0;
    repeat (hold) @(negedge clk);
    d = bus_out;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 preload", preload_val, 0);
    check("R1 reference", ref_val, 0);
    check("R1 mode", mode, 0);
    check("R1 pulses", pulse_vec(), 0);
    check("R2 oe idle", bus_oe, 0);
    latch_val = 24'h5A6B7C;
    host_rd(1'b1, d);
    check("R1 status", d, 8'h00);
    host_rd(1'b0, d);
    check("R1 pointer at byte 0", d, 8'h7C);
  endtask

  task automatic t_write_regs();
    logic [7:0] d;
    host_wr(1'b1, 8'h80);
    for (int i = 0; i < 6; i++) host_wr(1'b0, 8'h11 * (i + 1));
    check("R3 preload bytes", preload_val, 24'h332211);
    check("R3 reference bytes", ref_val, 24'h665544);
    latch_val = 24'hA1B2C3;
    host_rd(1'b0, d);
    check("R4 wrap after byte 5", d, 8'hC3);
  endtask

  task automatic t_read_bytes();
    logic [7:0] d;
    host_wr(1'b1, 8'h80);
    host_rd(1'b0, d); check("R5 latch byte0", d, 8'hC3);
    host_rd(1'b0, d); check("R5 latch byte1", d, 8'hB2);
    host_rd(1'b0, d); check("R5 latch byte2", d, 8'hA1);
    host_rd(1'b0, d); check("R5 ref byte0", d, 8'h44);
    host_rd(1'b0, d); check("R5 ref byte1", d, 8'h55);
    host_rd(1'b0, d); check("R5 ref byte2", d, 8'h66);
    host_rd(1'b0, d); check("R4 read wrap", d, 8'hC3);
  endtask

  task automatic t_held_strobe();
    logic [7:0] d;
    host_wr(1'b1, 8'h80);
    @(negedge clk);
    cs_n = 1'b0; cmd_sel = 1'b0; rd_n = 1'b0;
    #0.5 check("R2 oe follows strobe", bus_oe, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R6 held read data", bus_out, 8'hC3);
    end
    rd_n = 1'b1; cs_n = 1'b1;
    #0.5 check("R2 oe released", bus_oe, 0);
    host_rd(1'b0, d);
    check("R6 single advance", d, 8'hB2);
    @(negedge clk);
    cs_n = 1'b0; cmd_sel = 1'b1; bus_in = 8'h01; wr_n = 1'b0;
    @(negedge clk); check("R6 pulse first cycle", load_pulse, 1);
    @(negedge clk); check("R6 no repeat pulse", load_pulse, 0);
    @(negedge clk); check("R6 still no pulse", load_pulse, 0);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_ptr_set();
    logic [7:0] d;
    host_wr(1'b1, 8'h84);
    host_rd(1'b0, d); check("R7 pointer 4", d, 8'h55);
    host_wr(1'b1, 8'h87);
    host_rd(1'b0, d); check("R7 pointer 7 maps to 0", d, 8'hC3);
    host_wr(1'b1, 8'h86);
    host_rd(1'b0, d); check("R7 pointer 6 maps to 0", d, 8'hC3);
  endtask

  task automatic t_actions();
    logic [7:0] d;
    host_wr(1'b1, 8'h82);
    host_wr(1'b1, 8'h01); check("R8 load only", pulses_seen, 4'b0001);
    @(negedge clk); check("R8 pulse ends", pulse_vec(), 0);
    host_wr(1'b1, 8'h0A); check("R8 latch and irq ack", pulses_seen, 4'b1010);
    host_wr(1'b1, 8'h04); check("R8 clear only", pulses_seen, 4'b0100);
    host_wr(1'b1, 8'h0F); check("R8 all four", pulses_seen, 4'b1111);
    host_rd(1'b0, d); check("R12 actions keep pointer", d, 8'hA1);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    host_wr(1'b1, 8'h81);
    host_wr(1'b1, 8'hC5);
    check("R9 mode set", mode, 4'h5);
    check("R9 no pulses", pulses_seen, 0);
    host_rd(1'b0, d); check("R9 mode keeps pointer", d, 8'hB2);
    host_wr(1'b1, 8'hCA);
    check("R9 mode replaced", mode, 4'hA);
  endtask

  task automatic t_status();
    logic [7:0] d;
    host_wr(1'b1, 8'h83);
    @(negedge clk);
    abn_flag = 1; irq_state = 0; eq_flag = 1; dir_flag = 0;
    latch_valid = 1; pin_z = 0; pin_b = 1; pin_a = 0;
    repeat (2) @(negedge clk);
    host_rd(1'b1, d); check("R10 status pattern A", d, 8'b1010_1010);
    @(negedge clk);
    abn_flag = 0; irq_state = 1; eq_flag = 0; dir_flag = 1;
    latch_valid = 0; pin_z = 1; pin_b = 0; pin_a = 1;
    repeat (2) @(negedge clk);
    host_rd(1'b1, d); check("R10 status pattern B", d, 8'b0101_0101);
    host_rd(1'b0, d); check("R12 status keeps pointer", d, 8'h44);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    logic [23:0] pre_before;
    pre_before = preload_val;
    host_wr(1'b1, 8'h80);
    host_wr(1'b0, 8'hEE, 1'b0);
    check("R11 preload untouched", preload_val, pre_before);
    host_wr(1'b1, 8'h0F, 1'b0);
    check("R11 no pulses", pulses_seen, 0);
    host_wr(1'b1, 8'h85, 1'b0);
    @(negedge clk);
    cmd_sel = 1'b0; rd_n = 1'b0;
    #0.5 check("R11 oe low while disabled", bus_oe, 0);
    @(negedge clk); rd_n = 1'b1;
    host_rd(1'b0, d); check("R11 pointer held", d, 8'hC3);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_regs();
        t_read_bytes();
        t_held_strobe();
        t_ptr_set();
        t_actions();
        t_mode();
        t_status();
        t_disabled();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule